// File: doc/BRIEF.md
# Character Overlay Display Controller

This block places lines of text over a live pixel stream. The pixel source presents the current screen coordinate on every clock. One clock later the block reports whether that pixel falls inside the text window, and if it does, the colour that should replace the video. The text window is a single page of 24 character columns by 12 character rows. Its top-left corner sits at a programmable pixel origin. Each cell holds a 6-bit glyph code, a foreground colour, a background colour and a blink enable. Glyphs come from a 64-entry pattern store, and each glyph is 8 by 8 pixels.

All state is loaded through one write-only register port. The port selects a space (control, cell store or glyph store), an address and a data word. The control space holds the origin, a size/blink mode word and a batch-clear command. Glyphs can be stretched horizontally by 1 or 2 and vertically by 1, 2, 4 or 8. Blinking is timed by counting frame-start pulses. After a batch clear, and also after reset, every cell is rewritten with the blank default.

Top module: `text_overlay`

## Requirements
- R1: A pixel is in the window when org_x <= px_x < org_x + 192*hs and org_y <= px_y < org_y + 96*vs, where hs and vs are the horizontal and vertical stretch factors. Outside the window, ovl_valid is 0 and ovl_color is 0.
- R2: Inside the window, the pixel takes the cell's foreground colour where the glyph bit is 1 and the background colour where it is 0. Glyph-store address code*8+line holds one line of a glyph, with bit 7 as the leftmost pixel.
- R3: Cell-space address row*24+column writes data bits {12: blink, 11:9 background, 8:6 foreground, 5:0 code}. A cell address of 288 or above changes nothing.
- R4: Control address 2, bit 0 selects horizontal stretch: 0 gives 1x and 1 gives 2x (each glyph pixel spans 2 columns).
- R5: Control address 2, bits 2:1 select vertical stretch 1x, 2x, 4x or 8x (value v gives 2^v lines per glyph line).
- R6: A frame counter advances by one on each vsync_pulse. Control address 2, bit 3 selects a blink period of 32 (0) or 64 (1) frames, and the phase is the count modulo that period.
- R7: Control address 2, bits 5:4 set the blink on-time: 1, 2 or 3 means the phase is below 25%, 50% or 75% of the period. 0 means always on.
- R8: During the off-time, a cell with blink enabled shows only its background colour. Cells without blink enabled are unaffected.
- R9: A write to control address 3 starts a batch clear. clear_busy stays high for exactly 288 cycles while every cell is set to code 0, foreground 7, background 0, blink 0. Cell writes made during the clear are discarded.
- R10: After reset, origin and mode are 0, the frame counter is 0, ovl_valid is 0, and clear_busy is high while an automatic batch clear runs.
- R11: The overlay outputs are registered and reflect the coordinate presented one clock earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| px_x | input | 11 | Current pixel column |
| px_y | input | 11 | Current pixel line |
| vsync_pulse | input | 1 | One-cycle frame-start pulse |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 2 | Space: 0 control, 1 cells, 2 glyphs |
| reg_addr | input | 9 | Address within the space |
| reg_wdata | input | 13 | Write data |
| ovl_valid | output | 1 | Pixel lies inside the text window |
| ovl_color | output | 3 | Overlay colour for the pixel |
| clear_busy | output | 1 | Batch clear in progress |

## Verification
A wrong cell index or glyph line shows up as a colour mismatch on the very next cycle after the affected coordinate is presented. For that reason, whole scan lines are compared pixel by pixel at each stretch setting and across the window edges. A frame counter that is off by one is not visible until the phase crosses a duty boundary, so blink is checked on both sides of each boundary and at the period wrap. A clear walk that is one entry short or long changes the busy duration, which is counted cycle by cycle. A discarded write that was not actually discarded reappears in the scan that follows the clear.

// File: rtl/txo_pkg.sv
package txo_pkg;

    parameter int COLS      = 24;
    parameter int ROWS      = 12;
    parameter int GLYPHS    = 64;
    parameter int GLYPH_PX  = 8;
    parameter int COLOR_W   = 3;
    parameter int COORD_W   = 11;
    parameter int ADDR_W    = 9;
    parameter int VCNT_W    = 6;

    localparam int CELLS      = COLS * ROWS;
    localparam int CODE_W     = $clog2(GLYPHS);
    localparam int CELL_AW    = $clog2(CELLS);
    localparam int GSH        = $clog2(GLYPH_PX);
    localparam int FONT_DEPTH = GLYPHS * GLYPH_PX;
    localparam int FONT_AW    = $clog2(FONT_DEPTH);
    localparam int SPAN_X     = COLS * GLYPH_PX;
    localparam int SPAN_Y     = ROWS * GLYPH_PX;
    localparam int DATA_W     = 1 + 2 * COLOR_W + CODE_W;

    typedef struct packed {
        logic               blink;
        logic [COLOR_W-1:0] bg;
        logic [COLOR_W-1:0] fg;
        logic [CODE_W-1:0]  code;
    } cell_t;

    typedef struct packed {
        logic [1:0] duty;
        logic       per64;
        logic [1:0] vsh;
        logic       hsh;
    } mode_t;

    typedef enum logic [1:0] {
        SP_CTRL = 2'd0,
        SP_CELL = 2'd1,
        SP_FONT = 2'd2,
        SP_NONE = 2'd3
    } space_e;

    localparam logic [ADDR_W-1:0] CA_ORGX  = 'd0;
    localparam logic [ADDR_W-1:0] CA_ORGY  = 'd1;
    localparam logic [ADDR_W-1:0] CA_MODE  = 'd2;
    localparam logic [ADDR_W-1:0] CA_CLEAR = 'd3;

    localparam cell_t CELL_BLANK = '{blink: 1'b0, bg: '0, fg: '1, code: '0};

    function automatic logic [COORD_W:0] stretch_span(input int unsigned base,
                                                      input logic [1:0] sh);
        logic [COORD_W:0] b;
        b = (COORD_W+1)'(base);
        return b << sh;
    endfunction

endpackage

// File: rtl/txo_ctrl.sv
module txo_ctrl
    import txo_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                reg_we,
    input  logic [1:0]          reg_sel,
    input  logic [ADDR_W-1:0]   reg_addr,
    input  logic [DATA_W-1:0]   reg_wdata,
    output logic [COORD_W-1:0]  org_x,
    output logic [COORD_W-1:0]  org_y,
    output mode_t               mode,
    output logic                clr_start,
    output logic                cell_we,
    output logic [CELL_AW-1:0]  cell_addr,
    output cell_t               cell_data,
    output logic                font_we,
    output logic [FONT_AW-1:0]  font_addr,
    output logic [GLYPH_PX-1:0] font_data
);

    space_e sp;
    logic   ctrl_we;

    assign sp      = space_e'(reg_sel);
    assign ctrl_we = reg_we && (sp == SP_CTRL);

    always_ff @(posedge clk) begin
        if (rst) begin
            org_x <= '0;
            org_y <= '0;
            mode  <= '0;
        end else if (ctrl_we) begin
            case (reg_addr)
                CA_ORGX: org_x <= reg_wdata[COORD_W-1:0];
                CA_ORGY: org_y <= reg_wdata[COORD_W-1:0];
                CA_MODE: mode  <= mode_t'(reg_wdata[$bits(mode_t)-1:0]);
                default: ;
            endcase
        end
    end

    assign clr_start = ctrl_we && (reg_addr == CA_CLEAR);
    assign cell_we   = reg_we && (sp == SP_CELL);
    assign cell_addr = reg_addr[CELL_AW-1:0];
    assign cell_data = cell_t'(reg_wdata);
    assign font_we   = reg_we && (sp == SP_FONT);
    assign font_addr = reg_addr[FONT_AW-1:0];
    assign font_data = reg_wdata[GLYPH_PX-1:0];

endmodule

// File: rtl/txo_store.sv
module txo_store
    import txo_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                clr_start,
    input  logic                cell_we,
    input  logic [CELL_AW-1:0]  cell_addr,
    input  cell_t               cell_data,
    input  logic                font_we,
    input  logic [FONT_AW-1:0]  font_addr,
    input  logic [GLYPH_PX-1:0] font_data,
    input  logic [CELL_AW-1:0]  rd_cell_idx,
    input  logic [FONT_AW-1:0]  rd_font_addr,
    output cell_t               rd_cell,
    output logic [GLYPH_PX-1:0] rd_font_row,
    output logic                busy
);

    cell_t               cells [CELLS];
    logic [GLYPH_PX-1:0] glyph [FONT_DEPTH];
    logic [CELL_AW-1:0]  walk_idx;

    // Clear sequencer: reset behaves like a clear command.
    always_ff @(posedge clk) begin
        if (rst || clr_start) begin
            busy     <= 1'b1;
            walk_idx <= '0;
        end else if (busy) begin
            if (walk_idx == CELL_AW'(CELLS - 1)) begin
                busy <= 1'b0;
            end else begin
                walk_idx <= walk_idx + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (busy) begin
            cells[walk_idx] <= CELL_BLANK;
        end else if (cell_we && (cell_addr < CELL_AW'(CELLS))) begin
            cells[cell_addr] <= cell_data;
        end
    end

    always_ff @(posedge clk) begin
        if (font_we) begin
            glyph[font_addr] <= font_data;
        end
    end

    assign rd_cell     = cells[rd_cell_idx];
    assign rd_font_row = glyph[rd_font_addr];

    p_walk_in_range_r9: assert property (@(posedge clk) disable iff (rst)
        busy |-> (walk_idx < CELL_AW'(CELLS)));

    p_walk_ends_r9: assert property (@(posedge clk) disable iff (rst)
        (busy && walk_idx == CELL_AW'(CELLS - 1) && !clr_start) |=> !busy);

endmodule

// File: rtl/txo_blink.sv
module txo_blink
    import txo_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  vsync_pulse,
    input  mode_t mode,
    output logic  blink_on
);

    logic [VCNT_W-1:0] vcnt;
    logic [VCNT_W-1:0] phase;
    logic [VCNT_W:0]   on_limit;

    always_ff @(posedge clk) begin
        if (rst) begin
            vcnt <= '0;
        end else if (vsync_pulse) begin
            vcnt <= vcnt + 1'b1;
        end
    end

    // Period is 32 or 64 frames; on-time is duty quarters of it.
    always_comb begin
        phase    = mode.per64 ? vcnt : {1'b0, vcnt[VCNT_W-2:0]};
        on_limit = (VCNT_W+1)'(mode.duty) << (mode.per64 ? VCNT_W - 2 : VCNT_W - 3);
        blink_on = (mode.duty == 2'd0) || ({1'b0, phase} < on_limit);
    end

    p_count_hold_r6: assert property (@(posedge clk) disable iff (rst)
        !vsync_pulse |=> $stable(vcnt));

    p_count_step_r6: assert property (@(posedge clk) disable iff (rst)
        vsync_pulse |=> (vcnt == $past(vcnt) + 1'b1));

endmodule

// File: rtl/txo_render.sv
module txo_render
    import txo_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic [COORD_W-1:0]  px_x,
    input  logic [COORD_W-1:0]  px_y,
    input  logic [COORD_W-1:0]  org_x,
    input  logic [COORD_W-1:0]  org_y,
    input  mode_t               mode,
    input  logic                blink_on,
    input  cell_t               rd_cell,
    input  logic [GLYPH_PX-1:0] rd_font_row,
    output logic [CELL_AW-1:0]  rd_cell_idx,
    output logic [FONT_AW-1:0]  rd_font_addr,
    output logic                ovl_valid,
    output logic [COLOR_W-1:0]  ovl_color
);

    logic [COORD_W:0]   rx, ry, span_x, span_y;
    logic               in_win, pix_on, show_fg;
    logic [CELL_AW-1:0] col_i, row_i;
    logic [GSH-1:0]     gx, gy;
    logic [COLOR_W-1:0] color_n;

    always_comb begin
        rx     = {1'b0, px_x} - {1'b0, org_x};
        ry     = {1'b0, px_y} - {1'b0, org_y};
        span_x = stretch_span(SPAN_X, {1'b0, mode.hsh});
        span_y = stretch_span(SPAN_Y, mode.vsh);
        in_win = !rx[COORD_W] && !ry[COORD_W] && (rx < span_x) && (ry < span_y);

        col_i  = CELL_AW'(rx >> (GSH + int'(mode.hsh)));
        row_i  = CELL_AW'(ry >> (GSH + int'(mode.vsh)));
        gx     = GSH'(rx >> mode.hsh);
        gy     = GSH'(ry >> mode.vsh);

        rd_cell_idx  = in_win ? (row_i * CELL_AW'(COLS) + col_i) : '0;
        rd_font_addr = {rd_cell.code, gy};

        pix_on  = rd_font_row[GSH'(GLYPH_PX - 1) - gx];
        show_fg = pix_on && !(rd_cell.blink && !blink_on);
        color_n = in_win ? (show_fg ? rd_cell.fg : rd_cell.bg) : '0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ovl_valid <= 1'b0;
            ovl_color <= '0;
        end else begin
            ovl_valid <= in_win;
            ovl_color <= color_n;
        end
    end

    p_left_of_origin_r1: assert property (@(posedge clk) disable iff (rst)
        (px_x < org_x) |=> (!ovl_valid && ovl_color == '0));

    p_above_origin_r1: assert property (@(posedge clk) disable iff (rst)
        (px_y < org_y) |=> !ovl_valid);

endmodule

// File: rtl/text_overlay.sv
module text_overlay
    import txo_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic [COORD_W-1:0]  px_x,
    input  logic [COORD_W-1:0]  px_y,
    input  logic                vsync_pulse,
    input  logic                reg_we,
    input  logic [1:0]          reg_sel,
    input  logic [ADDR_W-1:0]   reg_addr,
    input  logic [DATA_W-1:0]   reg_wdata,
    output logic                ovl_valid,
    output logic [COLOR_W-1:0]  ovl_color,
    output logic                clear_busy
);

    logic [COORD_W-1:0]  org_x, org_y;
    mode_t               mode;
    logic                clr_start, cell_we, font_we, blink_on;
    logic [CELL_AW-1:0]  cell_addr, rd_cell_idx;
    cell_t               cell_data, rd_cell;
    logic [FONT_AW-1:0]  font_addr, rd_font_addr;
    logic [GLYPH_PX-1:0] font_data, rd_font_row;

    txo_ctrl i_ctrl (
        .clk       (clk),
        .rst       (rst),
        .reg_we    (reg_we),
        .reg_sel   (reg_sel),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .org_x     (org_x),
        .org_y     (org_y),
        .mode      (mode),
        .clr_start (clr_start),
        .cell_we   (cell_we),
        .cell_addr (cell_addr),
        .cell_data (cell_data),
        .font_we   (font_we),
        .font_addr (font_addr),
        .font_data (font_data)
    );

    txo_store i_store (
        .clk          (clk),
        .rst          (rst),
        .clr_start    (clr_start),
        .cell_we      (cell_we),
        .cell_addr    (cell_addr),
        .cell_data    (cell_data),
        .font_we      (font_we),
        .font_addr    (font_addr),
        .font_data    (font_data),
        .rd_cell_idx  (rd_cell_idx),
        .rd_font_addr (rd_font_addr),
        .rd_cell      (rd_cell),
        .rd_font_row  (rd_font_row),
        .busy         (clear_busy)
    );

    txo_blink i_blink (
        .clk         (clk),
        .rst         (rst),
        .vsync_pulse (vsync_pulse),
        .mode        (mode),
        .blink_on    (blink_on)
    );

    txo_render i_render (
        .clk          (clk),
        .rst          (rst),
        .px_x         (px_x),
        .px_y         (px_y),
        .org_x        (org_x),
        .org_y        (org_y),
        .mode         (mode),
        .blink_on     (blink_on),
        .rd_cell      (rd_cell),
        .rd_font_row  (rd_font_row),
        .rd_cell_idx  (rd_cell_idx),
        .rd_font_addr (rd_font_addr),
        .ovl_valid    (ovl_valid),
        .ovl_color    (ovl_color)
    );

    p_quiet_colour_r1: assert property (@(posedge clk) disable iff (rst)
        !ovl_valid |-> (ovl_color == '0));

endmodule

// File: tb/test_text_overlay.sv
module test_text_overlay;
    import txo_pkg::*;

    logic                clk = 1'b0;
    logic                rst = 1'b1;
    logic [COORD_W-1:0]  px_x = '0;
    logic [COORD_W-1:0]  px_y = '0;
    logic                vsync_pulse = 1'b0;
    logic                reg_we = 1'b0;
    logic [1:0]          reg_sel = '0;
    logic [ADDR_W-1:0]   reg_addr = '0;
    logic [DATA_W-1:0]   reg_wdata = '0;
    logic                ovl_valid;
    logic [COLOR_W-1:0]  ovl_color;
    logic                clear_busy;

    text_overlay i_text_overlay (
        .clk(clk), .rst(rst), .px_x(px_x), .px_y(px_y), .vsync_pulse(vsync_pulse),
        .reg_we(reg_we), .reg_sel(reg_sel), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .ovl_valid(ovl_valid), .ovl_color(ovl_color), .clear_busy(clear_busy)
    );

    always #2 clk = ~clk;

    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;

    // Bench shadow state
    cell_t               sh_cell [CELLS];
    logic [GLYPH_PX-1:0] sh_font [FONT_DEPTH];
    int                  ox = 0, oy = 0, vcnt = 0;
    mode_t               sm = '0;

    // Scoreboard queues
    logic [3:0] q_exp [$];
    string      q_tag [$];
    int         q_x [$], q_y [$];

    task automatic check(input bit ok, input string tag, input int act, input int expv);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
        end
    endtask

    function automatic logic [3:0] model(input int x, input int y);
        int cw, ch, col, row, gx, gy, per, ph;
        bit on, bitv;
        cell_t c;
        cw = 8 * (sm.hsh ? 2 : 1);
        ch = 8 * (1 << sm.vsh);
        if (x < ox || y < oy || x >= ox + 24 * cw || y >= oy + 12 * ch) return 4'b0;
        col = (x - ox) / cw;
        row = (y - oy) / ch;
        gx  = ((x - ox) % cw) / (cw / 8);
        gy  = ((y - oy) % ch) / (ch / 8);
        c   = sh_cell[row * 24 + col];
        per = sm.per64 ? 64 : 32;
        ph  = vcnt % per;
        on  = (sm.duty == 0) || (ph * 4 < per * int'(sm.duty));
        bitv = sh_font[int'(c.code) * 8 + gy][7 - gx];
        if (bitv && !(c.blink && !on)) return {1'b1, c.fg};
        return {1'b1, c.bg};
    endfunction

    // Monitor: compares the result of the coordinate pushed at this edge
    always @(posedge clk) begin
        #2;
        if (q_exp.size() > 0) begin
            logic [3:0] e;
            string t;
            int x, y;
            e = q_exp.pop_front(); t = q_tag.pop_front();
            x = q_x.pop_front();   y = q_y.pop_front();
            checks++;
            if ({ovl_valid, ovl_color} !== e) begin
                failures++;
                $display("FAIL %s at (%0d,%0d) actual=%0h expected=%0h", t, x, y,
                         {ovl_valid, ovl_color}, e);
            end
        end
    end

    task automatic wr(input int sel, input int addr, input int data);
        reg_we = 1'b1; reg_sel = 2'(sel); reg_addr = ADDR_W'(addr); reg_wdata = DATA_W'(data);
        @(posedge clk); #1;
        reg_we = 1'b0;
    endtask

    task automatic set_mode(input mode_t m);
        wr(0, 2, int'(m)); sm = m;
    endtask

    task automatic put_cell(input int col, input int row, input int code, input int fg,
                            input int bg, input bit bl);
        cell_t c;
        c = '{blink: bl, bg: COLOR_W'(bg), fg: COLOR_W'(fg), code: CODE_W'(code)};
        wr(1, row * 24 + col, int'(c));
        sh_cell[row * 24 + col] = c;
    endtask

    task automatic px(input int x, input int y, input string tag);
        logic [3:0] e;
        e = model(x, y);
        px_x = COORD_W'(x); px_y = COORD_W'(y);
        @(posedge clk);
        q_exp.push_back(e); q_tag.push_back(tag); q_x.push_back(x); q_y.push_back(y);
        #1;
    endtask

    task automatic scan_line(input int y, input int x0, input int x1, input int step,
                             input string tag);
        for (int x = x0; x <= x1; x += step) px(x, y, tag);
    endtask

    task automatic vpulse();
        vsync_pulse = 1'b1;
        @(posedge clk); #1;
        vsync_pulse = 1'b0;
        vcnt = (vcnt + 1) % 64;
    endtask

    task automatic vpulse_to(input int n);
        while (vcnt != n) vpulse();
    endtask

    task automatic blink_scan(input string tag);
        for (int gy = 0; gy < 8; gy++) scan_line(oy + 16 + gy, ox, ox + 63, 1, tag);
        scan_line(oy + 3, ox, ox + 63, 1, tag);
    endtask

    task automatic blank_all();
        for (int i = 0; i < CELLS; i++) sh_cell[i] = CELL_BLANK;
    endtask

    task automatic wait_idle(output int n);
        n = 0;
        while (clear_busy && n < 2000) begin
            n++;
            @(posedge clk); #1;
        end
    endtask

    initial begin
        #(200000 * 4);
        if (!finished) begin
            failures++; checks++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        int n;
        mode_t m;
        repeat (4) @(posedge clk);
        #1 rst = 1'b0;
        // R10: reset state
        check(clear_busy === 1'b1, "R10 busy after reset", int'(clear_busy), 1);
        check(ovl_valid === 1'b0, "R10 valid after reset", int'(ovl_valid), 0);
        check(ovl_color === '0, "R10 colour after reset", int'(ovl_color), 0);
        wait_idle(n);
        check(n == CELLS, "R10 auto clear length", n, CELLS);
        blank_all();

        // glyph store
        for (int i = 0; i < FONT_DEPTH; i++) begin
            logic [7:0] p;
            p = 8'((i * 37 + 91) ^ (i >> 2));
            sh_font[i] = p;
            wr(2, i, int'(p));
        end

        // R10: origin 0 and mode 0 after reset, default cells
        scan_line(0, 0, 20, 1, "R10");
        scan_line(7, 186, 194, 1, "R10");

        // R3: cells, including an out-of-range address
        for (int c = 0; c < 24; c++) put_cell(c, 0, c + 1, c % 8, (c + 3) % 8, 1'b0);
        for (int c = 0; c < 24; c += 5) put_cell(c, 11, 63 - c, 7 - (c % 8), c % 8, 1'b0);
        put_cell(23, 5, 42, 2, 5, 1'b0);
        wr(1, 300, 13'h1ABC);
        wr(1, 511, 13'h0FFF);
        wr(0, 0, 100); ox = 100;
        wr(0, 1, 50);  oy = 50;

        // R1/R2 at 1x
        scan_line(oy - 1, ox - 2, ox + 193, 1, "R1");
        scan_line(oy, ox - 2, ox + 193, 1, "R2");
        scan_line(oy + 3, ox - 2, ox + 193, 1, "R2");
        scan_line(oy + 7, ox - 2, ox + 193, 1, "R2");
        scan_line(oy + 8, ox - 2, ox + 193, 1, "R3");
        scan_line(oy + 44, ox + 170, ox + 193, 1, "R3");
        scan_line(oy + 88, ox - 2, ox + 193, 1, "R3");
        scan_line(oy + 95, ox - 2, ox + 193, 1, "R1");
        scan_line(oy + 96, ox - 2, ox + 193, 1, "R1");
        px(ox - 1, oy - 1, "R1");
        px(0, 0, "R1");

        // R11: alternate inside/outside every cycle
        for (int i = 0; i < 16; i++) px((i % 2) ? ox + i : ox - 1 - i, oy + 2, "R11");

        // R4/R5 stretch
        m = '0; m.hsh = 1'b1; m.vsh = 2'd2; set_mode(m);
        for (int y = oy - 1; y <= oy + 385; y += 13) scan_line(y, ox - 2, ox + 385, 3, "R4");
        scan_line(oy + 383, ox + 380, ox + 386, 1, "R4");
        m = '0; m.vsh = 2'd3; set_mode(m);
        for (int y = oy; y <= oy + 770; y += 37) scan_line(y, ox - 2, ox + 193, 4, "R5");
        scan_line(oy + 767, ox, ox + 40, 1, "R5");
        scan_line(oy + 768, ox, ox + 10, 1, "R5");
        m = '0; m.vsh = 2'd1; set_mode(m);
        for (int y = oy; y < oy + 40; y++) scan_line(y, ox, ox + 30, 1, "R5");

        // R6/R7/R8 blinking
        for (int c = 0; c < 8; c++) put_cell(c, 2, c + 10, (c + 1) % 8, (c + 5) % 8, c < 6);
        m = '0; m.duty = 2'd1; set_mode(m);
        vpulse_to(7);  blink_scan("R7");
        vpulse_to(8);  blink_scan("R8");
        vpulse_to(31); blink_scan("R8");
        vpulse_to(32); blink_scan("R6");
        m.duty = 2'd2; set_mode(m);
        vpulse_to(47); blink_scan("R7");
        vpulse_to(48); blink_scan("R7");
        m.per64 = 1'b1; m.duty = 2'd3; set_mode(m);
        blink_scan("R6");
        vpulse_to(47); blink_scan("R7");
        vpulse_to(63); blink_scan("R8");
        vpulse(); blink_scan("R6");
        vpulse_to(40); blink_scan("R6");
        m.duty = 2'd0; set_mode(m);
        vpulse_to(60); blink_scan("R7");

        // R9: clear timing
        wr(0, 3, 0);
        wait_idle(n);
        check(n == CELLS, "R9 busy duration", n, CELLS);
        blank_all();
        scan_line(oy, ox, ox + 193, 1, "R9");
        scan_line(oy + 88, ox, ox + 193, 1, "R9");

        // R9: writes during a clear are discarded
        put_cell(3, 0, 33, 4, 6, 1'b0);
        wr(0, 3, 0);
        check(clear_busy === 1'b1, "R9 busy after command", int'(clear_busy), 1);
        wr(1, 5, 13'h0A49);
        wr(1, 24 * 2 + 1, 13'h1155);
        wait_idle(n);
        check(n == CELLS - 2, "R9 remaining busy", n, CELLS - 2);
        check(clear_busy === 1'b0, "R9 idle after clear", int'(clear_busy), 0);
        blank_all();
        for (int y = oy; y < oy + 24; y += 2) scan_line(y, ox, ox + 63, 1, "R9");

        repeat (4) @(posedge clk);
        #1;
        check(q_exp.size() == 0, "R11 scoreboard drained", q_exp.size(), 0);
        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule